// File: doc/BRIEF.md
# Phase-Correct Dual-Channel PWM Generator

This block drives two pulse-width-modulated outputs from one shared counter. The counter climbs from zero to a peak and then falls back to zero, so each edge of a pulse sits the same distance from the counter turning points. This keeps the pulse centres of both channels aligned whatever their duty. The peak depends on the selected resolution (8, 9 or 10 bits). Each channel has a compare value and a polarity bit. When the counter equals the compare value, the output is set or cleared, depending on whether the counter is rising or falling.

Software reaches the block through a simple register write port. There is one control register holding the mode and the two polarity bits. Each channel has a compare value split into a low byte and a high byte. Compare writes land in a holding copy. That copy is moved into the active compare only in the cycle the rising counter reaches its peak, so a change never cuts a pulse short. The write port has no back-pressure: every strobe is taken in the cycle it is presented. The intended write order is low byte, high byte, then control.

Top module: `pwm_pc_dual`

## Requirements
- R1: After reset the mode is disabled, both outputs are low, both compare holding copies are zero and both active compares are 1.
- R2: While the mode field is 00 (disabled), the counter is held at zero and rising, and both outputs are driven low from the next cycle on.
- R3: Mode 01 sets the peak to 255, mode 10 to 511 and mode 11 to 1023. The output period is then 512, 1024 or 2048 clocks.
- R4: The counter increments to the peak, stays there one extra cycle while turning to falling, decrements to zero, and stays at zero one extra cycle while turning to rising.
- R5: With polarity 0, a match while rising drives the output low in the next cycle, and a match while falling drives it high. For an active compare a, the high pulse lasts 2a+1 clocks.
- R6: With polarity 1, a match while rising drives the output high and a match while falling drives it low. The high pulse lasts 2(peak−a)+1 clocks.
- R7: Only the compare bits that fit the selected resolution take part: the holding copy is masked with the peak value before use.
- R8: Compare writes go to the holding copy. The active compare changes only on the clock edge that ends a rising cycle at the peak. A write presented in that same cycle is committed at the following peak instead.
- R9: A masked compare of 0 is committed as 1, and a masked compare equal to the peak is committed as peak−1.
- R10: The two channels share the counter but have independent compare values and polarity.
- R11: The register map is as follows. Address 0 is control: bits 1:0 are the mode, bit 2 is the channel 0 polarity, and bit 3 is the channel 1 polarity. Addresses 1 and 2 are the low byte and high bits 9:8 of channel 0. Addresses 3 and 4 are the same for channel 1. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| pwm_out | output | 2 | PWM outputs, bit c is channel c |

## Verification
The delicate coincidence is a compare write arriving in the very cycle the rising counter sits at its peak. In that cycle the commit copies the old holding value while the new byte lands in the holding copy. The bench provokes this by timing from an observed falling edge of channel 0: with a known compare a, the peak cycle lies a fixed number of clocks after that edge. It then checks two things: the next pulse still has the old width, and only the pulse after it shows the new value. A second coincidence is a match in the same cycle as a mode write. This one is judged against the per-clock reference model, which applies writes only after the cycle's counting.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;

  typedef enum logic [1:0] {
    PWM_OFF  = 2'b00,
    PWM_RES8 = 2'b01,
    PWM_RES9 = 2'b10,
    PWM_RES10 = 2'b11
  } pwm_mode_e;

  // control register field positions
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_POL_LSB  = 2;

  // address of the control register; channel c uses 1+2c (low) and 2+2c (high)
  localparam int ADDR_CTL = 0;

endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 3,
  parameter int N_CH   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output pwm_mode_e                      mode_o,
  output logic [N_CH-1:0]                pol_o,
  output logic [N_CH-1:0][CNT_W-1:0]     hold_o
);

  localparam int HI_W = CNT_W - DATA_W;

  logic ctl_sel;
  assign ctl_sel = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= PWM_OFF;
      pol_o  <= '0;
    end else if (ctl_sel) begin
      mode_o <= pwm_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
      pol_o  <= wr_data[CTL_POL_LSB +: N_CH];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_hold
    localparam int LO_ADDR = 1 + 2 * c;
    localparam int HI_ADDR = 2 + 2 * c;
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(LO_ADDR)) lo_q <= wr_data;
        if (wr_addr == ADDR_W'(HI_ADDR)) hi_q <= wr_data[HI_W-1:0];
      end
    end

    assign hold_o[c] = {hi_q, lo_q};
  end

endmodule

// File: rtl/pwm_updown_ctr.sv
module pwm_updown_ctr
  import pwm_pc_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int RES_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwm_mode_e        mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic [CNT_W-1:0] peak_o,
  output logic             at_peak_o
);

  logic [CNT_W:0] span;

  // peak = 2^(RES_MIN-1+mode) - 1, zero when disabled
  always_comb begin
    if (mode_i == PWM_OFF) begin
      span = '0;
    end else begin
      span = ((CNT_W+1)'(1) << (RES_MIN - 1 + int'(mode_i))) - (CNT_W+1)'(1);
    end
  end

  assign peak_o    = span[CNT_W-1:0];
  assign at_peak_o = (mode_i != PWM_OFF) && up_o && (cnt_o == peak_o);

  always_ff @(posedge clk) begin
    if (!rst_n || mode_i == PWM_OFF) begin
      cnt_o <= '0;
      up_o  <= 1'b1;
    end else if (up_o) begin
      if (cnt_o >= peak_o) begin
        cnt_o <= peak_o;
        up_o  <= 1'b0;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end else begin
      if (cnt_o == '0) begin
        up_o <= 1'b1;
      end else begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] peak_i,
  input  logic             at_peak_i,
  output logic [CNT_W-1:0] act_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] masked;
  logic [CNT_W-1:0] legal;
  logic             hit;

  always_comb begin
    masked = hold_i & peak_i;
    if (masked == '0)          legal = CNT_W'(1);
    else if (masked >= peak_i) legal = peak_i - 1'b1;
    else                       legal = masked;
  end

  assign hit = (cnt_i == (act_o & peak_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_o <= CNT_W'(1);
    end else if (at_peak_i) begin
      act_o <= legal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      pwm_o <= 1'b0;
    end else if (hit) begin
      pwm_o <= up_i ? pol_i : ~pol_i;
    end
  end

endmodule

// File: rtl/pwm_pc_dual.sv
module pwm_pc_dual
  import pwm_pc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RES_MIN = 8,
  parameter int ADDR_W  = 3,
  parameter int N_CH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_CH-1:0]   pwm_out
);

  localparam int CNT_W = RES_MIN + 2;

  pwm_mode_e                    mode_q;
  logic [N_CH-1:0]              pol_q;
  logic [N_CH-1:0][CNT_W-1:0]   hold_q;
  logic [N_CH-1:0][CNT_W-1:0]   act_cmp;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             cnt_peak;
  logic                         cnt_up;
  logic                         at_peak;

  pwm_regbank #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .N_CH(N_CH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_o(mode_q), .pol_o(pol_q), .hold_o(hold_q)
  );

  pwm_updown_ctr #(
    .CNT_W(CNT_W), .RES_MIN(RES_MIN)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q),
    .cnt_o(cnt_q), .up_o(cnt_up), .peak_o(cnt_peak), .at_peak_o(at_peak)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .run_i(mode_q != PWM_OFF), .pol_i(pol_q[c]),
      .hold_i(hold_q[c]), .cnt_i(cnt_q), .up_i(cnt_up), .peak_i(cnt_peak),
      .at_peak_i(at_peak), .act_o(act_cmp[c]), .pwm_o(pwm_out[c])
    );
  end

endmodule

// File: rtl/pwm_pc_dual_chk.sv
module pwm_pc_dual_chk #(
  parameter int CNT_W = 10,
  parameter int N_CH  = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [1:0]                   mode,
  input logic [CNT_W-1:0]             cnt,
  input logic                         cnt_up,
  input logic [CNT_W-1:0]             cnt_peak,
  input logic [N_CH-1:0][CNT_W-1:0]   act,
  input logic [N_CH-1:0]              pwm_out
);

  a_r2_off_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (pwm_out == '0));

  a_r2_off_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (cnt == '0 && cnt_up));

  a_r4_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && cnt_up && cnt < cnt_peak) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r4_top_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && cnt_up && cnt == cnt_peak) |=> (cnt == $past(cnt) && !cnt_up));

  a_r4_bottom_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && !cnt_up && cnt == '0) |=> (cnt == '0 && cnt_up));

  a_r8_hold_between_peaks: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode != 2'b00 && cnt_up && cnt == cnt_peak) |=> (act == $past(act)));

  for (genvar c = 0; c < N_CH; c++) begin : g_act
    a_r9_act_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      act[c] != '0);
  end

endmodule

bind pwm_pc_dual pwm_pc_dual_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .cnt(cnt_q), .cnt_up(cnt_up),
  .cnt_peak(cnt_peak), .act(act_cmp), .pwm_out(pwm_out)
);

// File: tb/pwm_pc_dual_tb.sv
module pwm_pc_dual_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mode, m_cnt, m_up, m_mx, m_v;
  int m_pol[2];
  int m_sh[2];
  int m_act[2];
  int m_out[2];

  always #2 clk = ~clk;

  pwm_pc_dual u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_up = 1;
      for (int c = 0; c < 2; c++) begin
        m_pol[c] = 0; m_sh[c] = 0; m_act[c] = 1; m_out[c] = 0;
      end
    end else begin
      m_mx = (m_mode == 0) ? 0 : ((1 << (7 + m_mode)) - 1);
      if (m_mode == 0) begin
        m_cnt = 0; m_up = 1;
        for (int c = 0; c < 2; c++) m_out[c] = 0;
      end else begin
        for (int c = 0; c < 2; c++)
          if (m_cnt == (m_act[c] & m_mx)) m_out[c] = m_up ? m_pol[c] : (1 - m_pol[c]);
        if (m_up == 1 && m_cnt == m_mx) begin
          for (int c = 0; c < 2; c++) begin
            m_v = m_sh[c] & m_mx;
            if (m_v == 0) m_v = 1;
            else if (m_v >= m_mx) m_v = m_mx - 1;
            m_act[c] = m_v;
          end
        end
        if (m_up == 1) begin
          if (m_cnt >= m_mx) begin m_cnt = m_mx; m_up = 0; end
          else m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) m_up = 1;
        else m_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = wr_data[1:0]; m_pol[0] = wr_data[2]; m_pol[1] = wr_data[3]; end
          3'd1: m_sh[0] = (m_sh[0] & 'h300) | wr_data;
          3'd2: m_sh[0] = (m_sh[0] & 'hFF) | (int'(wr_data[1:0]) << 8);
          3'd3: m_sh[1] = (m_sh[1] & 'h300) | wr_data;
          3'd4: m_sh[1] = (m_sh[1] & 'hFF) | (int'(wr_data[1:0]) << 8);
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      for (int c = 0; c < 2; c++) begin
        n_chk++;
        if (int'(pwm_out[c]) != m_out[c]) begin
          n_fail++;
          $display("FAIL %s ch%0d cycle compare: got %0d expected %0d", cur_req, c, pwm_out[c], m_out[c]);
        end
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(input int c);
    int g = 0;
    while (pwm_out[c] == 1'b1 && g < 6000) begin @(negedge clk); g++; end
    while (pwm_out[c] == 1'b0 && g < 12000) begin @(negedge clk); g++; end
  endtask

  task automatic high_width(input int c, output int w);
    wait_rise(c);
    w = 0;
    while (pwm_out[c] == 1'b1 && w < 6000) begin w++; @(negedge clk); end
  endtask

  task automatic period_of(input int c, output int p);
    wait_rise(c);
    p = 0;
    while (pwm_out[c] == 1'b1 && p < 6000) begin p++; @(negedge clk); end
    while (pwm_out[c] == 1'b0 && p < 6000) begin p++; @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    finish_run();
  end

  initial begin
    int w;
    int p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 reset outputs", int'(pwm_out), 0);

    // R2: disabled, compare writes do not start anything
    cur_req = "R2";
    wr(3'd1, 8'd100); wr(3'd2, 8'd0);
    wr(3'd3, 8'd200); wr(3'd4, 8'd0);
    repeat (40) @(negedge clk);
    chk("R2 disabled outputs low", int'(pwm_out), 0);

    // 8-bit mode, ch0 polarity 0, ch1 polarity 1
    cur_req = "R3";
    wr(3'd0, 8'h09);
    repeat (600) @(negedge clk);
    cur_req = "R5";
    high_width(0, w);
    chk("R5 pol0 width a=100", w, 201);
    cur_req = "R6";
    high_width(1, w);
    chk("R6 pol1 width a=200", w, 111);
    cur_req = "R3";
    period_of(0, p);
    chk("R3 period 8-bit", p, 512);
    cur_req = "R10";
    period_of(1, p);
    chk("R10 ch1 period shared counter", p, 512);

    // R7: bits above resolution are ignored (0x105 -> 5)
    cur_req = "R7";
    wr(3'd1, 8'd5); wr(3'd2, 8'd1);
    repeat (1100) @(negedge clk);
    high_width(0, w);
    chk("R7 masked compare width", w, 11);

    // R9: clamping of 0 and peak
    cur_req = "R9";
    wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    repeat (1100) @(negedge clk);
    high_width(0, w);
    chk("R9 zero clamps to 1", w, 3);
    wr(3'd1, 8'hFF); wr(3'd2, 8'h03);
    repeat (1100) @(negedge clk);
    high_width(0, w);
    chk("R9 peak clamps to peak-1", w, 509);

    // R8: write during a pulse does not cut it
    cur_req = "R8";
    wr(3'd1, 8'd100); wr(3'd2, 8'd0);
    repeat (1100) @(negedge clk);
    wait_rise(0);
    wr(3'd1, 8'd50);
    w = 2;
    while (pwm_out[0] == 1'b1 && w < 6000) begin w++; @(negedge clk); end
    chk("R8 pulse keeps old compare", w, 201);
    high_width(0, w);
    chk("R8 next pulse uses new compare", w, 101);

    // R8: write landing in the peak cycle waits one more period
    wr(3'd1, 8'd100);
    repeat (1100) @(negedge clk);
    high_width(0, w);
    repeat (153) @(negedge clk);
    wr(3'd1, 8'd30);
    high_width(0, w);
    chk("R8 peak-cycle write not yet active", w, 201);
    high_width(0, w);
    chk("R8 peak-cycle write active one period later", w, 61);

    // R11: unmapped addresses change nothing
    cur_req = "R11";
    wr(3'd5, 8'hFF); wr(3'd6, 8'h00); wr(3'd7, 8'h0F);
    high_width(0, w);
    chk("R11 unmapped writes ignored ch0", w, 61);
    high_width(1, w);
    chk("R11 unmapped writes ignored ch1", w, 111);

    // R2: disable mid-run
    cur_req = "R2";
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk("R2 disable drives low", int'(pwm_out), 0);

    // R3/R4: 9-bit and 10-bit periods
    cur_req = "R3";
    wr(3'd1, 8'd100);
    wr(3'd0, 8'h0A);
    repeat (1100) @(negedge clk);
    period_of(0, p);
    chk("R3 period 9-bit", p, 1024);
    cur_req = "R4";
    high_width(1, w);
    chk("R4 pol1 width 9-bit a=200", w, 623);
    wr(3'd0, 8'h00);
    cur_req = "R3";
    wr(3'd0, 8'h0B);
    repeat (2100) @(negedge clk);
    period_of(0, p);
    chk("R3 period 10-bit", p, 2048);
    cur_req = "R5";
    high_width(0, w);
    chk("R5 pol0 width 10-bit a=100", w, 201);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule